// File: doc/BRIEF.md
# Processor Bus Bank Latch and Address Decoder

This block is the glue between a 16-bit-address processor bus that sends its bank byte on the data lines during the low phase of the phase-2 clock and the memories and peripherals behind it. While phase 2 is low it passes the bank byte straight through as the upper address bits. While phase 2 is high it holds that value. A parameter sets how many bank bits are kept; a 1-bit build gives a 128 KB space.

The full address is split into a RAM select, a ROM select and eight 16-byte peripheral selects in the upper half of page zero of bank 0. All selects are active low. Chip selects and the peripheral read/write line come from the address alone, so they settle before phase 2 rises. The memory read and write strobes are qualified by phase 2 high, so a write cannot reach a location while the address is still unstable.

A cycle in which both valid-address flags are low is internal: it gets no select and no strobe. An optional abort request marks an access to an unpopulated bank with a one-clock pulse. The block runs on a system clock `clk` that is faster than phase 2.

Top module: `bus_glue`

## Requirements
- R1: `bank_o` equals `data_i` while `phi2_i` is low. While `phi2_i` is high it holds the byte sampled on the last `clk` edge at which `phi2_i` was low.
- R2: `bank_o` is `BANK_BITS` wide (default 8) and carries `data_i[BANK_BITS-1:0]` unchanged, including the top bit.
- R3: `oe_n_o` is low exactly when `phi2_i` is high, `rw_i` is 1 (read) and `vda_i` or `vpa_i` is high.
- R4: `we_n_o` is low exactly when `phi2_i` is high, `rw_i` is 0 (write) and `vda_i` or `vpa_i` is high. It is never low while `phi2_i` is low.
- R5: In bank 0, addresses 0x0080–0x00FF drive `io_cs_n_o[k]` low, where k = address bits 6:4 (0x0080–0x008F is block 0, 0x00F0–0x00FF is block 7). This select does not depend on `phi2_i`.
- R6: `ram_cs_n_o` is low for bank 0, addresses 0x0000–0x7FFF, outside the peripheral window. It is also low for any address in banks 1 to `POP_BANKS-1` (default 4).
- R7: `rom_cs_n_o` is low for bank 0, addresses 0x8000–0xFFFF.
- R8: When `vda_i` and `vpa_i` are both low, every select and strobe stays high.
- R9: If `clk` samples the first high `phi2_i` of a cycle with a valid address in an unpopulated bank (`POP_BANKS` or above), `abort_n_o` goes low for exactly one `clk` cycle, starting on the next edge. Populated accesses and internal cycles cause no pulse.
- R10: While `rst_n` is low, and up to the first rising `clk` edge after it goes high, `bank_o` is 0 and every select, strobe and abort output is high.
- R11: `io_rw_o` follows `rw_i` while a peripheral select is low. Otherwise it is 1. It does not depend on `phi2_i`.
- R12: At most one of the RAM, ROM and peripheral selects is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, faster than phase 2 |
| rst_n | input | 1 | synchronous active-low reset |
| phi2_i | input | 1 | processor phase-2 clock |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 16 | low address bits A0–A15 |
| data_i | input | 8 | data bus, carries the bank byte while phase 2 is low |
| vda_i | input | 1 | valid data address flag |
| vpa_i | input | 1 | valid program address flag |
| bank_o | output | BANK_BITS | latched upper address bits |
| ram_cs_n_o | output | 1 | RAM select, active low |
| rom_cs_n_o | output | 1 | ROM select, active low |
| io_cs_n_o | output | IO_BLOCKS | peripheral block selects, active low |
| io_rw_o | output | 1 | read/write line to peripherals |
| oe_n_o | output | 1 | read strobe, active low |
| we_n_o | output | 1 | write strobe, active low |
| abort_n_o | output | 1 | abort request, active low |

## Verification
The assertions sample on `clk` edges. They assume that `phi2_i`, `rw_i`, the address, the flags and the data bus change only between edges. They also assume that phase 2 stays low across at least one edge before it rises, so the hold check always compares two held samples. The bench drives every input on the falling edge of `clk` and holds each phase for at least one full clock, which meets these assumptions. Its checks read the outputs one time unit after the drive, well before the next rising edge.

// File: rtl/glue_pkg.sv
// Shared types for the bus glue: the address region picked by the decoder.
package glue_pkg;
    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_RAM  = 2'd1,
        REGION_ROM  = 2'd2,
        REGION_IO   = 2'd3
    } region_e;
endpackage

// File: rtl/glue_bank_latch.sv
// Bank byte capture. It is passed through while phase 2 is low and held
// while phase 2 is high. Assumes clk samples phase 2 low at least once
// per cycle. Output is forced to zero until live_i is set after reset.
module glue_bank_latch #(
    parameter int BANK_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 live_i,
    input  logic                 phi2_i,
    input  logic [BANK_BITS-1:0] data_i,
    output logic [BANK_BITS-1:0] bank_o
);
    logic [BANK_BITS-1:0] bank_q;

    // Track the bus byte during the low phase; keep it during the high phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (!phi2_i) bank_q <= data_i;
    end

    // Transparent in the low phase, held in the high phase, zero until live.
    always_comb begin
        if (!live_i)     bank_o = '0;
        else if (phi2_i) bank_o = bank_q;
        else             bank_o = data_i;
    end
endmodule

// File: rtl/glue_addr_decode.sv
// Address decoder for the full bank:address. Bank 0 holds RAM below 0x8000
// with a peripheral window in the upper half of page zero, and ROM above.
// Banks 1..POP_BANKS-1 are RAM. Anything else is unpopulated.
// Purely combinational; validity qualification is done by the caller.
module glue_addr_decode
    import glue_pkg::*;
#(
    parameter int BANK_BITS = 8,
    parameter int POP_BANKS = 4,
    parameter int IO_BLOCKS = 8,
    localparam int IDX_W    = $clog2(IO_BLOCKS)
) (
    input  logic [BANK_BITS-1:0] bank_i,
    input  logic [15:0]          addr_i,
    output region_e              region_o,
    output logic [IDX_W-1:0]     io_idx_o
);
    localparam logic [BANK_BITS:0] POP_LIM = (BANK_BITS+1)'(POP_BANKS);

    logic bank_zero, in_window, bank_pop;

    // Classify the bank and the page-zero peripheral window.
    always_comb begin
        bank_zero = (bank_i == '0);
        bank_pop  = ({1'b0, bank_i} < POP_LIM);
        in_window = (addr_i >= 16'h0080) && (addr_i <= 16'h00FF);
        io_idx_o  = addr_i[4 +: IDX_W];
    end

    // Pick one region per address.
    always_comb begin
        if (bank_zero) begin
            if (addr_i[15])     region_o = REGION_ROM;
            else if (in_window) region_o = REGION_IO;
            else                region_o = REGION_RAM;
        end else if (bank_pop) begin
            region_o = REGION_RAM;
        end else begin
            region_o = REGION_NONE;
        end
    end
endmodule

// File: rtl/glue_strobe_abort.sv
// Read and write strobes qualified by phase 2 high, plus the one-clock
// abort pulse raised on the first clk sample of phase 2 high when the
// access falls on unpopulated space. Assumes phase 2 changes between clk edges.
module glue_strobe_abort #(
    parameter bit ABORT_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic phi2_i,
    input  logic rw_i,
    input  logic valid_i,
    input  logic unpop_i,
    output logic oe_n_o,
    output logic we_n_o,
    output logic abort_n_o
);
    logic phi2_q;

    // Remember phase 2 from the previous edge to find its rising sample.
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_q <= 1'b0;
        else        phi2_q <= phi2_i;
    end

    // Strobes only in phase 2 high of a valid, live cycle.
    always_comb begin
        oe_n_o = !(live_i && valid_i && phi2_i &&  rw_i);
        we_n_o = !(live_i && valid_i && phi2_i && !rw_i);
    end

    generate
        if (ABORT_EN) begin : g_abort
            logic abort_q;
            // Single pulse: the rising-sample condition lasts one edge only.
            always_ff @(posedge clk) begin
                if (!rst_n) abort_q <= 1'b0;
                else        abort_q <= live_i && valid_i && unpop_i && phi2_i && !phi2_q;
            end
            assign abort_n_o = !abort_q;
        end else begin : g_no_abort
            logic unused_unpop;
            assign unused_unpop = unpop_i;
            assign abort_n_o    = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/bus_glue.sv
// Top of the bus glue: bank capture, decode, select gating and strobes.
// Selects and peripheral R/W come from address only and are not gated by
// phase 2. Memory strobes are gated by phase 2 high. Assumes inputs change
// between clk edges and phase 2 is low for at least one clk edge per cycle.
module bus_glue
    import glue_pkg::*;
#(
    parameter int BANK_BITS = 8,
    parameter int POP_BANKS = 4,
    parameter int IO_BLOCKS = 8,
    parameter bit ABORT_EN  = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 phi2_i,
    input  logic                 rw_i,
    input  logic [15:0]          addr_i,
    input  logic [7:0]           data_i,
    input  logic                 vda_i,
    input  logic                 vpa_i,
    output logic [BANK_BITS-1:0] bank_o,
    output logic                 ram_cs_n_o,
    output logic                 rom_cs_n_o,
    output logic [IO_BLOCKS-1:0] io_cs_n_o,
    output logic                 io_rw_o,
    output logic                 oe_n_o,
    output logic                 we_n_o,
    output logic                 abort_n_o
);
    localparam int IDX_W = $clog2(IO_BLOCKS);

    logic             live_q;
    logic             valid, enable;
    region_e          region;
    logic [IDX_W-1:0] io_idx;

    // Outputs stay quiet until one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // A cycle is external when either valid-address flag is high.
    always_comb begin
        valid  = vda_i || vpa_i;
        enable = live_q && valid;
    end

    glue_bank_latch #(.BANK_BITS(BANK_BITS)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .live_i (live_q),
        .phi2_i (phi2_i),
        .data_i (data_i[BANK_BITS-1:0]),
        .bank_o (bank_o)
    );

    glue_addr_decode #(
        .BANK_BITS (BANK_BITS),
        .POP_BANKS (POP_BANKS),
        .IO_BLOCKS (IO_BLOCKS)
    ) u_decode (
        .bank_i   (bank_o),
        .addr_i   (addr_i),
        .region_o (region),
        .io_idx_o (io_idx)
    );

    glue_strobe_abort #(.ABORT_EN(ABORT_EN)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_i    (live_q),
        .phi2_i    (phi2_i),
        .rw_i      (rw_i),
        .valid_i   (valid),
        .unpop_i   (region == REGION_NONE),
        .oe_n_o    (oe_n_o),
        .we_n_o    (we_n_o),
        .abort_n_o (abort_n_o)
    );

    // Memory selects from address and validity only.
    always_comb begin
        ram_cs_n_o = !(enable && region == REGION_RAM);
        rom_cs_n_o = !(enable && region == REGION_ROM);
        io_rw_o    = (enable && region == REGION_IO) ? rw_i : 1'b1;
    end

    // One active-low select per peripheral block.
    generate
        for (genvar g = 0; g < IO_BLOCKS; g++) begin : g_io
            assign io_cs_n_o[g] = !(enable && region == REGION_IO && io_idx == IDX_W'(g));
        end
    endgenerate

    // R1: bank byte holds across consecutive high-phase samples
    a_r1_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2_i && $past(phi2_i) && $past(live_q)) |-> (bank_o == $past(bank_o)));

    // R3: read strobe only in a valid high-phase read
    a_r3_oe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> (phi2_i && rw_i && (vda_i || vpa_i)));

    // R4: write strobe only in a valid high-phase write
    a_r4_we_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> (phi2_i && !rw_i && (vda_i || vpa_i)));

    // R8: internal cycles drive nothing
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(vda_i || vpa_i) |-> (ram_cs_n_o && rom_cs_n_o && (&io_cs_n_o) && oe_n_o && we_n_o));

    // R9: abort pulse lasts a single clock
    a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n_o |=> abort_n_o);

    // R12: never two selects at once
    a_r12_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ram_cs_n_o, ~rom_cs_n_o, ~io_cs_n_o}));
endmodule

// File: tb/bus_glue_bench.sv
module bus_glue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0, rw = 1'b1, vda = 1'b0, vpa = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic [7:0]  bank;
    logic        ram_n, rom_n, io_rw, oe_n, we_n, abort_n;
    logic [7:0]  io_n;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_glue u_bus_glue (
        .clk(clk), .rst_n(rst_n), .phi2_i(phi2), .rw_i(rw), .addr_i(addr),
        .data_i(data), .vda_i(vda), .vpa_i(vpa), .bank_o(bank),
        .ram_cs_n_o(ram_n), .rom_cs_n_o(rom_n), .io_cs_n_o(io_n),
        .io_rw_o(io_rw), .oe_n_o(oe_n), .we_n_o(we_n), .abort_n_o(abort_n)
    );

    // {bank, addr, rw, vda, vpa, exp ram_n, exp rom_n, exp io_n}
    localparam logic [36:0] VEC [NVEC] = '{
        {8'h00, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},  // R6 low RAM read
        {8'h00, 16'h0085, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFE},  // R5 block 0 write
        {8'h00, 16'h00F3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h7F},  // R5 block 7
        {8'h00, 16'h00A0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFB},  // R5 block 2
        {8'h00, 16'h9000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF},  // R7 ROM
        {8'h00, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF},  // R7 top of ROM
        {8'h00, 16'h007F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},  // R6 just below window
        {8'h02, 16'h0080, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},  // R6 window only in bank 0
        {8'h03, 16'hC000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},  // R6 last populated bank
        {8'h04, 16'h1000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF},  // R6 first unpopulated bank
        {8'h00, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF},  // R8 internal cycle
        {8'h00, 16'h0090, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFD}   // R5 block 1 via vpa
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Low phase with the bank on data, then high phase with junk on data.
    task automatic bus_cycle(input logic [36:0] v);
        logic [7:0] b = v[36:29];
        logic       r = v[12];
        logic       val = v[11] | v[10];
        logic [7:0] eio = v[7:0];
        @(negedge clk);
        phi2 = 1'b0; data = b; addr = v[28:13]; rw = r; vda = v[11]; vpa = v[10];
        #1;
        chk("R1 low-phase bank", 32'(bank), 32'(b));
        chk("R5 select before phi2", 32'(io_n), 32'(eio));
        chk("R11 io rw before phi2", 32'(io_rw), 32'((eio != 8'hFF) ? r : 1'b1));
        chk("R4 no strobe in low phase", 32'({oe_n, we_n}), 32'(2'b11));
        @(negedge clk);
        phi2 = 1'b1; data = ~b;
        #1;
        chk("R1 held bank", 32'(bank), 32'(b));
        chk("R6 ram select", 32'(ram_n), 32'(v[9]));
        chk("R7 rom select", 32'(rom_n), 32'(v[8]));
        chk("R5 io select", 32'(io_n), 32'(eio));
        chk("R3 read strobe", 32'(oe_n), 32'(!(val && r)));
        chk("R4 write strobe", 32'(we_n), 32'(!(val && !r)));
        @(negedge clk);
        phi2 = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state with an active-looking write in flight
        phi2 = 1'b1; rw = 1'b0; vda = 1'b1; addr = 16'h0085; data = 8'h07;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 bank in reset", 32'(bank), 32'h0);
        chk("R10 strobes in reset", 32'({oe_n, we_n, abort_n}), 32'(3'b111));
        chk("R10 selects in reset", 32'({ram_n, rom_n, io_n}), 32'h3FF);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 quiet until first edge", 32'({we_n, io_n}), 32'h1FF);
        @(negedge clk);
        phi2 = 1'b0; vda = 1'b0;

        for (int i = 0; i < NVEC; i++) bus_cycle(VEC[i]);

        // R1: transparency follows data, then holds last sampled byte
        @(negedge clk);
        phi2 = 1'b0; vda = 1'b1; rw = 1'b1; addr = 16'h2000; data = 8'h03;
        #1; chk("R1 transparent", 32'(bank), 32'h03);
        data = 8'h06;
        #1; chk("R1 transparent update", 32'(bank), 32'h06);
        @(negedge clk);
        phi2 = 1'b1; data = 8'h01;
        #1; chk("R1 hold in high phase", 32'(bank), 32'h06);
        @(negedge clk);
        #1; chk("R1 hold second sample", 32'(bank), 32'h06);

        // R2: top bank bit carried through; 0x83 is unpopulated
        @(negedge clk);
        phi2 = 1'b0; data = 8'h83;
        @(negedge clk);
        phi2 = 1'b1; data = 8'h00;
        #1; chk("R2 full-width bank", 32'(bank), 32'h83);
        chk("R2 high bank no ram", 32'(ram_n), 32'h1);

        // R9: unpopulated bank 5 gives one abort clock
        @(negedge clk);
        phi2 = 1'b0; data = 8'h05; addr = 16'h2000; vda = 1'b1;
        @(negedge clk);
        phi2 = 1'b1;
        #1; chk("R9 no abort before edge", 32'(abort_n), 32'h1);
        @(negedge clk);
        #1; chk("R9 abort asserted", 32'(abort_n), 32'h0);
        @(negedge clk);
        #1; chk("R9 abort one clock only", 32'(abort_n), 32'h1);

        // R9: populated bank gives no abort
        @(negedge clk);
        phi2 = 1'b0; data = 8'h01;
        @(negedge clk);
        phi2 = 1'b1;
        @(negedge clk);
        #1; chk("R9 populated no abort", 32'(abort_n), 32'h1);

        // R8/R9: internal cycle on unpopulated bank gives no abort
        @(negedge clk);
        phi2 = 1'b0; data = 8'h09; vda = 1'b0; vpa = 1'b0;
        @(negedge clk);
        phi2 = 1'b1;
        @(negedge clk);
        #1; chk("R8 internal no abort", 32'(abort_n), 32'h1);

        // R11: peripheral write shows rw low, non-peripheral keeps it high
        @(negedge clk);
        phi2 = 1'b0; data = 8'h00; vda = 1'b1; rw = 1'b0; addr = 16'h00C4;
        #1; chk("R11 io write rw", 32'(io_rw), 32'h0);
        addr = 16'h4000;
        #1; chk("R11 non-io rw high", 32'(io_rw), 32'h1);

        // R12: one select only across several addresses
        #1; chk("R12 single select", 32'($countones(~{ram_n, rom_n, io_n})), 32'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule